// File: doc/BRIEF.md
# Windowed Register Access Bridge

This block connects a host-side register master, which addresses a large register map with flat 32-bit byte offsets, to a device register bus whose directly decoded aperture covers only the low part of that map. Offsets below 0x80000 reach the device bus unchanged. Larger offsets are translated. The block first writes a window number to a window-select register on the device. It then performs the access through a fixed aperture that starts at 0x80000. The window number most recently written is held in a small cache, so a run of accesses to the same window costs one select write in total.

The sequencer is a four-state machine. `ST_IDLE` accepts a request. The transition `idle->select` is taken when a translated access needs a new window. The transition `idle->access` is taken for a direct access or when the cached window already matches. `ST_SELECT` drives the select write, and the transition `select->access` is taken on its acknowledge, at which point the cache is loaded. `ST_ACCESS` drives the real read or write, and the transition `access->reply` is taken on its acknowledge. `ST_REPLY` pulses the response for one cycle, and the transition `reply->idle` follows. A static input turns translation on or off.

Top module: `win_access_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, and `bus_req` and `rsp_valid` are 0.
- R2: With windowing enabled, an offset below 0x80000 produces exactly one bus transaction at that same address, with the same direction and write data.
- R3: With windowing disabled, every offset produces exactly one bus transaction at the unchanged offset, and no select write is issued.
- R4: For an offset of 0x80000 or more with windowing enabled, the window number is offset[23:19]. When a select write is needed, it is a write to address 0x310C. Its data has bit 31 set to 1 and the window number in bits [4:0].
- R5: A translated access is issued to address 0x80000 + offset[18:0], with the request's direction and write data.
- R6: A select write is issued only when the window number differs from the cached one. After the select write is acknowledged, the cache holds the new number.
- R7: The cache resets to 0. A first translated access whose window number is 0 (for example offset 0x01000040) issues no select write.
- R8: From acceptance until the response, `req_ready` stays 0. A select write is followed directly by its aperture access, with no other transaction in between.
- R9: While `bus_req` is 1 and `bus_ack` is 0, `bus_req`, `bus_addr`, `bus_write` and `bus_wdata` hold their values.
- R10: `rsp_valid` is a single-cycle pulse. For a read, `rsp_rdata` carries the data the device returned for the aperture or direct access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_enable | input | 1 | Static: 1 enables offset translation |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | 32 | Flat byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_valid` |
| bus_req | output | 1 | Device bus request |
| bus_addr | output | 32 | Device bus address |
| bus_write | output | 1 | Device bus direction |
| bus_wdata | output | 32 | Device bus write data |
| bus_ack | input | 1 | Device bus acknowledge |
| bus_rdata | input | 32 | Device bus read data, valid with `bus_ack` |

## Verification
Take W as the number of wait cycles the device inserts before each acknowledge. A request accepted on a rising edge then gets its response pulse after 2+W rising edges when it needs a single transaction, and after 2·(2+W) edges when a select write comes first. The scoreboard records the edge count at acceptance. It also records the expected latency, which it derives from its own model of the window cache. The monitor samples on falling edges only and compares the elapsed edge count exactly. At that same moment it checks the read data, the number of select writes, the number of bus transactions and the last bus address against values the driver predicted. Runs are made with W set to 0 and to 2, so both the held-request path and the immediate acknowledge are timed.

// File: rtl/winbr_pkg.sv
package winbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_ACCESS = 2'd2,
        ST_REPLY  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/winbr_xlate.sv
module winbr_xlate #(
    parameter int AW        = 32,
    parameter int WIN_SHIFT = 19,
    parameter int WIN_W     = 5
) (
    input  logic [AW-1:0]    offset,
    input  logic             win_en,
    input  logic [WIN_W-1:0] cur_win,
    output logic             windowed,
    output logic [WIN_W-1:0] win_num,
    output logic [AW-1:0]    mapped,
    output logic             need_sel
);
    localparam logic [AW-1:0] ONE      = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] APERTURE = ONE << WIN_SHIFT;
    localparam logic [AW-1:0] LOW_MASK = APERTURE - ONE;

    always_comb begin
        windowed = win_en && (offset >= APERTURE);
        win_num  = offset[WIN_SHIFT +: WIN_W];
        mapped   = windowed ? (APERTURE | (offset & LOW_MASK)) : offset;
        need_sel = windowed && (win_num != cur_win);
    end
endmodule

// File: rtl/winbr_wincache.sv
module winbr_wincache #(
    parameter int WIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIN_W-1:0] load_win,
    output logic [WIN_W-1:0] cur_win
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_win <= '0;
        else if (load)
            cur_win <= load_win;
    end

    p_cache_reset_r7: assert property (@(posedge clk)
        $rose(rst_n) |-> (cur_win == '0));
endmodule

// File: rtl/winbr_seq.sv
module winbr_seq
    import winbr_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter int          WIN_W    = 5,
    parameter logic [31:0] SEL_ADDR = 32'h0000_310C,
    parameter int          EN_BIT   = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [DW-1:0]    req_wdata,
    input  logic [AW-1:0]    map_addr,
    input  logic [WIN_W-1:0] win_num,
    input  logic             need_sel,
    output logic             bus_req,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_write,
    output logic [DW-1:0]    bus_wdata,
    input  logic             bus_ack,
    input  logic [DW-1:0]    bus_rdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             cache_load,
    output logic [WIN_W-1:0] cache_win
);
    seq_state_t        state, nxt;
    logic [AW-1:0]     acc_addr;
    logic              acc_write;
    logic [DW-1:0]     acc_wdata;
    logic [WIN_W-1:0]  acc_win;
    logic [DW-1:0]     rdata_q;
    logic [DW-1:0]     sel_data;
    logic              accept;

    assign accept = req_valid && (state == ST_IDLE);

    always_comb begin
        sel_data              = '0;
        sel_data[EN_BIT]      = 1'b1;
        sel_data[WIN_W-1:0]   = acc_win;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = need_sel ? ST_SELECT : ST_ACCESS;
            ST_SELECT: if (bus_ack) nxt = ST_ACCESS;
            ST_ACCESS: if (bus_ack) nxt = ST_REPLY;
            ST_REPLY:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // request capture and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr  <= '0;
            acc_write <= 1'b0;
            acc_wdata <= '0;
            acc_win   <= '0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                acc_addr  <= map_addr;
                acc_write <= req_write;
                acc_wdata <= req_wdata;
                acc_win   <= win_num;
            end
            if (state == ST_ACCESS && bus_ack)
                rdata_q <= bus_rdata;
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        bus_req    = 1'b0;
        bus_addr   = acc_addr;
        bus_write  = acc_write;
        bus_wdata  = acc_wdata;
        rsp_valid  = 1'b0;
        cache_load = 1'b0;
        cache_win  = acc_win;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_SELECT: begin
                bus_req    = 1'b1;
                bus_addr   = SEL_ADDR[AW-1:0];
                bus_write  = 1'b1;
                bus_wdata  = sel_data;
                cache_load = bus_ack;
            end
            ST_ACCESS: bus_req   = 1'b1;
            ST_REPLY:  rsp_valid = 1'b1;
        endcase
    end

    assign rsp_rdata = rdata_q;

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_write) && $stable(bus_wdata)));

    p_atomic_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELECT && bus_ack) |=> (state == ST_ACCESS && !req_ready));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready);

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_sel_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr == SEL_ADDR[AW-1:0] && state == ST_SELECT)
            |-> (bus_write && bus_wdata[EN_BIT]));
endmodule

// File: rtl/win_access_bridge.sv
module win_access_bridge #(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          WIN_SHIFT = 19,
    parameter int          WIN_W     = 5,
    parameter logic [31:0] SEL_ADDR  = 32'h0000_310C,
    parameter int          EN_BIT    = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_enable,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);
    localparam logic [AW-1:0] APERTURE = {{(AW-1){1'b0}}, 1'b1} << WIN_SHIFT;

    logic             windowed;
    logic [WIN_W-1:0] win_num;
    logic [WIN_W-1:0] cur_win;
    logic [AW-1:0]    map_addr;
    logic             need_sel;
    logic             cache_load;
    logic [WIN_W-1:0] cache_win;

    winbr_xlate #(.AW(AW), .WIN_SHIFT(WIN_SHIFT), .WIN_W(WIN_W)) u_xlate (
        .offset   (req_addr),
        .win_en   (win_enable),
        .cur_win  (cur_win),
        .windowed (windowed),
        .win_num  (win_num),
        .mapped   (map_addr),
        .need_sel (need_sel)
    );

    winbr_wincache #(.WIN_W(WIN_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cache_load),
        .load_win (cache_win),
        .cur_win  (cur_win)
    );

    winbr_seq #(
        .AW(AW), .DW(DW), .WIN_W(WIN_W), .SEL_ADDR(SEL_ADDR), .EN_BIT(EN_BIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .map_addr   (map_addr),
        .win_num    (win_num),
        .need_sel   (need_sel),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_write  (bus_write),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .cache_load (cache_load),
        .cache_win  (cache_win)
    );

    p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (!win_enable || req_addr < APERTURE))
            |=> (bus_req && bus_addr == $past(req_addr) &&
                 bus_wdata == $past(req_wdata)));

    p_cached_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && windowed && win_num == cur_win)
            |=> (bus_req && bus_addr != SEL_ADDR[AW-1:0]));

    p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && windowed && win_num != cur_win)
            |=> (bus_req && bus_addr == SEL_ADDR[AW-1:0]));
endmodule

// File: tb/sim_win_access_bridge.sv
module sim_win_access_bridge;
    typedef struct {
        bit          rd;
        bit          wr;
        logic [31:0] exp_data;
        logic [31:0] exp_addr;
        int          lat;
        int          sel;
        int          txn;
        int          acc;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_enable = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic        dack = 1'b0;
    logic [31:0] drdata = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // device model state
    logic [31:0] dmem [logic [31:0]];
    logic [31:0] win_reg = '0;
    int          sel_cnt = 0;
    int          txn_cnt = 0;
    int          hold_err = 0;
    int          dev_wait = 0;
    int          wcnt = 0;
    logic [31:0] held_addr = '0;
    logic [31:0] last_addr = '0;
    logic        last_write = 1'b0;

    // bench reference state
    logic [31:0] refm [logic [31:0]];
    logic [4:0]  m_win = '0;
    int          e_sel = 0;
    int          e_txn = 0;
    item_t       q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    win_access_bridge u0 (
        .clk(clk), .rst_n(rst_n), .win_enable(win_enable),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_ack(dack), .bus_rdata(drdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dev_key(input logic [31:0] a);
        if (win_enable && a >= 32'h8_0000 && a < 32'h10_0000)
            return {8'h0, win_reg[4:0], a[18:0]};
        return a;
    endfunction

    // device: acknowledge after dev_wait held cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            dack <= 1'b0;
            wcnt = 0;
        end else if (bus_req && !dack) begin
            if (wcnt == 0) held_addr = bus_addr;
            else if (bus_addr != held_addr) hold_err++;
            if (wcnt < dev_wait) begin
                wcnt++;
            end else begin
                wcnt = 0;
                dack <= 1'b1;
                txn_cnt++;
                last_addr <= bus_addr;
                last_write <= bus_write;
                if (win_enable && bus_write && bus_addr == 32'h310C) begin
                    win_reg <= bus_wdata;
                    sel_cnt++;
                end else if (bus_write) begin
                    dmem[dev_key(bus_addr)] = bus_wdata;
                end else begin
                    drdata <= dmem.exists(dev_key(bus_addr)) ? dmem[dev_key(bus_addr)] : 32'h0;
                end
            end
        end else begin
            dack <= 1'b0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(cyc - it.acc == it.lat, {it.tag, " R10 latency"}, 32'(cyc - it.acc), 32'(it.lat));
                if (it.rd)
                    chk(rsp_rdata == it.exp_data, {it.tag, " R10 read data"}, rsp_rdata, it.exp_data);
                chk(sel_cnt == it.sel, {it.tag, " R6 select count"}, 32'(sel_cnt), 32'(it.sel));
                chk(txn_cnt == it.txn, {it.tag, " R8 transaction count"}, 32'(txn_cnt), 32'(it.txn));
                chk(last_addr == it.exp_addr, {it.tag, " R5 bus address"}, last_addr, it.exp_addr);
                chk(last_write == it.wr, {it.tag, " R5 direction"}, 32'(last_write), 32'(it.wr));
                chk(hold_err == 0, {it.tag, " R9 held address"}, 32'(hold_err), 32'h0);
                if (sel_cnt > 0)
                    chk(win_reg[31] && win_reg[4:0] == m_win, {it.tag, " R4 select data"},
                        win_reg, {27'h400_0000, m_win});
            end
        end
    end

    task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] d, input string tag);
        item_t it;
        bit win, sel;
        logic [31:0] key;
        win = win_enable && a >= 32'h8_0000;
        sel = win && (a[23:19] != m_win);
        if (sel) begin m_win = a[23:19]; e_sel++; end
        e_txn += sel ? 2 : 1;
        key = win ? {8'h0, a[23:0]} : a;
        it.rd = !wr;
        it.wr = wr;
        it.exp_data = refm.exists(key) ? refm[key] : 32'h0;
        if (wr) refm[key] = d;
        it.exp_addr = win ? {13'h1, a[18:0]} : a;
        it.lat = (sel ? 2 : 1) * (2 + dev_wait);
        it.sel = e_sel;
        it.txn = e_txn;
        it.tag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        it.acc = cyc;
        q.push_back(it);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R8 ready low while busy"}, 32'(req_ready), 32'h0);
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_req == 1'b0 && rsp_valid == 1'b0,
            "R1 reset outputs", {29'h0, req_ready, bus_req, rsp_valid}, 32'h4);
        rst_n = 1'b1;
        for (int w = 0; w <= 2; w += 2) begin
            dev_wait = w;
            access(32'h0000_0040, 1, 32'hA5A5_0040 + w, "R2 direct write");
            access(32'h0000_0040, 0, 0, "R2 direct read");
            if (w == 0)
                access(32'h0100_0040, 0, 0, "R7 window zero no select");
            access(32'h000A_0004, 1, 32'h1111_0000 + w, "R4 select then write");
            access(32'h000A_0004, 0, 0, "R6 same window read");
            access(32'h00C8_0010, 1, 32'h2222_0000 + w, "R4 window 25 write");
            access(32'h000A_0004, 0, 0, "R6 back to window 1");
            access(32'h0000_0100, 1, 32'h3333_0000 + w, "R2 low while windowed");
            access(32'h00C8_0010, 0, 0, "R5 window 25 read");
            access(32'h0000_0100, 0, 0, "R2 low read");
            win_enable = 1'b0;
            access(32'h000A_0008, 1, 32'h4444_0000 + w, "R3 disabled write");
            access(32'h000A_0008, 0, 0, "R3 disabled read");
            access(32'h00C8_0010, 0, 0, "R3 disabled high read");
            win_enable = 1'b1;
            access(32'h000A_0008, 0, 0, "R5 enabled read of flat data");
            access(32'h1234_5678, 1, 32'h5555_0000 + w, "R4 upper bits ignored");
            access(32'h0034_5678, 0, 0, "R4 alias read");
        end
        for (int i = 0; i < 12; i++)
            access((32'((i * 7 + 3) % 32) << 19) | (32'(i * 32'h1234) & 32'h7FFC),
                   1, 32'hC0DE_0000 + 32'(i), "R6 sweep write");
        for (int i = 11; i >= 0; i--)
            access((32'((i * 7 + 3) % 32) << 19) | (32'(i * 32'h1234) & 32'h7FFC),
                   0, 0, "R10 sweep read");
        chk(sel_cnt == e_sel, "R6 total selects", 32'(sel_cnt), 32'(e_sel));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=0x%08h expected=0x%08h", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule